// File: doc/BRIEF.md
# Character LCD Host Bus Interface

This block is the target side of the parallel bus through which a host microcontroller talks to a character LCD controller. The host drives a register-select line, a read/write line and an enable strobe. The block brings these strobes into the system clock domain and decodes each transfer as one of four kinds: an instruction write, a data write, a status read or a data read. It then completes the transfer when enable falls.

Instruction writes are latched and presented with a one-cycle strobe. An instruction can load the display address counter and can switch the bus between full-byte and half-byte width. Data writes are latched into the data register and step the address counter. A status read returns the busy flag together with the address counter. Every accepted write starts a fixed busy interval. A write that arrives while the block is busy is dropped and reported on an error pulse. The block never drives the shared data lines itself: it produces outgoing data and an output enable for the pad ring.

Top module: `lcd_host_if`

## Requirements
- R1: A write with host_rs=0 latches the byte into cmd_q and pulses cmd_stb for one cycle, three clock edges after enable is seen low.
- R2: A write with host_rs=1 latches the byte into wdat_q and pulses wdat_stb. A read with host_rs=1 returns wdat_q on bus_out.
- R3: A read with host_rs=0 returns the busy flag in bit 7 and the 7-bit address counter in bits 6..0.
- R4: Write data is the value on bus_in when the falling edge of host_en is sampled. Values present earlier in the enable-high window are discarded.
- R5: bus_oe is 1 only while the synchronized enable is high during a read (host_rw=1). It is 0 after reset and after every write or completed read.
- R6: Each accepted instruction or data write raises busy for exactly BUSY_CYCLES clock cycles, starting in the same cycle as its strobe.
- R7: A write that completes while busy is high produces no strobe and changes neither register nor address. Instead it pulses wr_err for one cycle.
- R8: An accepted instruction with bit 7 set loads its bits 6..0 into the address counter.
- R9: The address counter increments by one after each accepted data write and after each data read, and wraps from 127 to 0.
- R10: An accepted instruction with bit 5 set selects the bus width from its bit 4 (1 = 8-bit, 0 = 4-bit), which is shown on wide_mode. After reset the bus is 8-bit. A width change clears the nibble phase.
- R11: In 4-bit mode each byte takes two enable cycles, high nibble first, on bus lines 7..4. Bus lines 3..0 are ignored on writes and driven 0 on reads. A lone first nibble produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_en | input | 1 | Asynchronous transfer enable strobe from the host |
| host_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| host_rw | input | 1 | Direction: 1 read, 0 write |
| bus_in | input | 8 | Data lines as seen from the pad |
| bus_out | output | 8 | Data to drive onto the lines during reads |
| bus_oe | output | 1 | Output enable for the data lines |
| busy | output | 1 | Internal operation in progress |
| cmd_q | output | 8 | Last accepted instruction byte |
| cmd_stb | output | 1 | One-cycle pulse on an accepted instruction |
| wdat_q | output | 8 | Data register |
| wdat_stb | output | 1 | One-cycle pulse on an accepted data write |
| wr_err | output | 1 | One-cycle pulse on a write dropped while busy |
| wide_mode | output | 1 | 1 when the bus is 8 bits wide |

## Verification
Transfers are driven in every register-select and direction combination, in both bus widths, so that the instruction path, the data path and the status path can each be told apart by the byte that comes back. One write changes bus_in part-way through the enable-high window, which separates capture on the falling edge from capture on the rising edge. Writes are issued back to back inside the busy interval, and the busy length is counted exactly. An instruction that loads address 127 is followed by a data read, which exposes the wrap of the address counter. In 4-bit mode the lower lines carry junk values so that any leak of those lines shows up in the assembled byte.

// File: rtl/lcd_if_pkg.sv
package lcd_if_pkg;

   localparam int BYTE_W = 8;
   localparam int NIB_W  = BYTE_W / 2;
   localparam int ADR_W  = BYTE_W - 1;

   typedef enum logic [2:0] {
      ACC_NONE,
      ACC_CMD_WR,
      ACC_DAT_WR,
      ACC_STAT_RD,
      ACC_DAT_RD
   } acc_kind_e;

   // Bit positions inside an instruction byte.
   localparam int CMD_ADR_LOAD = 7;
   localparam int CMD_WIDTH_EN = 5;
   localparam int CMD_WIDTH_8  = 4;

   function automatic acc_kind_e decode_acc(input logic rs, input logic rw);
      case ({rs, rw})
         2'b00:   return ACC_CMD_WR;
         2'b01:   return ACC_STAT_RD;
         2'b10:   return ACC_DAT_WR;
         default: return ACC_DAT_RD;
      endcase
   endfunction

endpackage

// File: rtl/lcd_strobe_sync.sv
module lcd_strobe_sync #(
   parameter int STAGES = 2,
   parameter int W      = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw,
   output logic [W-1:0] synced,
   output logic         en_rise,
   output logic         en_fall
);
   logic [W-1:0] chain [STAGES];
   logic         en_prev;

   if (STAGES < 2) begin : g_bad_stages
      $error("lcd_strobe_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= raw;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign synced = chain[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_prev <= 1'b0;
      else        en_prev <= synced[0];
   end

   assign en_rise = synced[0] & ~en_prev;
   assign en_fall = ~synced[0] & en_prev;

endmodule

// File: rtl/lcd_busy_timer.sv
module lcd_busy_timer #(
   parameter int CYCLES = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(CYCLES);

   logic [CW-1:0] remain;

   if (CYCLES < 1) begin : g_bad_cycles
      $error("lcd_busy_timer: CYCLES must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            remain <= '0;
      else if (start)        remain <= LOAD;
      else if (remain != '0) remain <= remain - 1'b1;
   end

   assign busy = (remain != '0);

endmodule

// File: rtl/lcd_addr_counter.sv
module lcd_addr_counter #(
   parameter int AW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step,
   output logic [AW-1:0] value
);
   if (AW < 1) begin : g_bad_aw
      $error("lcd_addr_counter: AW must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    value <= '0;
      else if (load) value <= load_val;
      else if (step) value <= value + 1'b1;
   end

endmodule

// File: rtl/lcd_host_if.sv
module lcd_host_if
   import lcd_if_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int BUSY_CYCLES = 40,
   parameter bit NIBBLE_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_en,
   input  logic              host_rs,
   input  logic              host_rw,
   input  logic [BYTE_W-1:0] bus_in,
   output logic [BYTE_W-1:0] bus_out,
   output logic              bus_oe,
   output logic              busy,
   output logic [BYTE_W-1:0] cmd_q,
   output logic              cmd_stb,
   output logic [BYTE_W-1:0] wdat_q,
   output logic              wdat_stb,
   output logic              wr_err,
   output logic              wide_mode
);
   localparam int STRB_W = 3;

   logic [STRB_W-1:0] strb_s;
   logic              e_s, rs_s, rw_s;
   logic              e_rise, e_fall;
   logic              wide_q, phase_q;
   logic [NIB_W-1:0]  hi_q;
   logic              byte_done;
   logic [BYTE_W-1:0] wr_byte, rd_byte;
   logic [ADR_W-1:0]  addr_q;
   acc_kind_e         acc;
   logic              acc_cmd, acc_dat, drop_wr, rd_step;

   // ---------------- strobe synchronizer ----------------
   lcd_strobe_sync #(
      .STAGES (SYNC_STAGES),
      .W      (STRB_W)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw     ({host_rw, host_rs, host_en}),
      .synced  (strb_s),
      .en_rise (e_rise),
      .en_fall (e_fall)
   );

   assign e_s  = strb_s[0];
   assign rs_s = strb_s[1];
   assign rw_s = strb_s[2];

   // ---------------- transfer decode ----------------
   assign acc       = decode_acc(rs_s, rw_s);
   assign byte_done = e_fall & (wide_q | phase_q);
   assign wr_byte   = wide_q ? bus_in : {hi_q, bus_in[BYTE_W-1 -: NIB_W]};

   assign acc_cmd = byte_done & (acc == ACC_CMD_WR) & ~busy;
   assign acc_dat = byte_done & (acc == ACC_DAT_WR) & ~busy;
   assign drop_wr = byte_done & ~rw_s & busy;
   assign rd_step = byte_done & (acc == ACC_DAT_RD);

   // ---------------- width / nibble phase ----------------
   if (NIBBLE_EN) begin : g_nibble
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wide_q  <= 1'b1;
            phase_q <= 1'b0;
            hi_q    <= '0;
         end else if (e_fall) begin
            if (!wide_q && !phase_q) begin
               phase_q <= 1'b1;
               hi_q    <= bus_in[BYTE_W-1 -: NIB_W];
            end else begin
               phase_q <= 1'b0;
            end
            if (acc_cmd && wr_byte[CMD_WIDTH_EN]) begin
               wide_q  <= wr_byte[CMD_WIDTH_8];
               phase_q <= 1'b0;
            end
         end
      end
   end else begin : g_fixed_wide
      assign wide_q  = 1'b1;
      assign phase_q = 1'b0;
      assign hi_q    = '0;
   end

   assign wide_mode = wide_q;

   // ---------------- write registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         cmd_stb  <= 1'b0;
         wdat_q   <= '0;
         wdat_stb <= 1'b0;
         wr_err   <= 1'b0;
      end else begin
         cmd_stb  <= acc_cmd;
         wdat_stb <= acc_dat;
         wr_err   <= drop_wr;
         if (acc_cmd) cmd_q  <= wr_byte;
         if (acc_dat) wdat_q <= wr_byte;
      end
   end

   // ---------------- busy interval ----------------
   lcd_busy_timer #(
      .CYCLES (BUSY_CYCLES)
   ) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .start (acc_cmd | acc_dat),
      .busy  (busy)
   );

   // ---------------- address counter ----------------
   lcd_addr_counter #(
      .AW (ADR_W)
   ) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (acc_cmd & wr_byte[CMD_ADR_LOAD]),
      .load_val (wr_byte[ADR_W-1:0]),
      .step     (acc_dat | rd_step),
      .value    (addr_q)
   );

   // ---------------- read path ----------------
   always_comb begin
      rd_byte = (acc == ACC_DAT_RD) ? wdat_q : {busy, addr_q};
      if (wide_q)       bus_out = rd_byte;
      else if (phase_q) bus_out = {rd_byte[NIB_W-1:0], {NIB_W{1'b0}}};
      else              bus_out = {rd_byte[BYTE_W-1 -: NIB_W], {NIB_W{1'b0}}};
   end

   assign bus_oe = e_s & rw_s;

endmodule

// File: rtl/lcd_host_if_chk.sv
module lcd_host_if_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       cmd_stb,
   input logic       wdat_stb,
   input logic       wr_err,
   input logic [6:0] addr_q
);
   AST_ACCEPT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb || wdat_stb) |-> !$past(busy)); // R7

   AST_BUSY_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb || wdat_stb) |-> busy); // R6

   AST_DROP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> (!cmd_stb && !wdat_stb && $past(busy))); // R7

   AST_DATA_WRITE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      wdat_stb |-> (addr_q == 7'($past(addr_q) + 7'd1))); // R9

   AST_DROP_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> $stable(addr_q)); // R7
endmodule

bind lcd_host_if lcd_host_if_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .cmd_stb  (cmd_stb),
   .wdat_stb (wdat_stb),
   .wr_err   (wr_err),
   .addr_q   (addr_q)
);

// File: tb/test_lcd_host_if.sv
`timescale 1ns/1ps
module test_lcd_host_if;
   localparam int BUSY_N = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_en = 1'b0, host_rs = 1'b0, host_rw = 1'b0;
   logic [7:0] bus_in = 8'h00;
   logic [7:0] bus_out, cmd_q, wdat_q;
   logic       bus_oe, busy, cmd_stb, wdat_stb, wr_err, wide_mode;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // Behavioural reference state
   int exp_addr = 0;
   int exp_wdat = 0;

   always #2.5 clk = ~clk;

   lcd_host_if #(.BUSY_CYCLES(BUSY_N)) i_lcd_host_if (
      .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_rs(host_rs),
      .host_rw(host_rw), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
      .busy(busy), .cmd_q(cmd_q), .cmd_stb(cmd_stb), .wdat_q(wdat_q),
      .wdat_stb(wdat_stb), .wr_err(wr_err), .wide_mode(wide_mode)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // Per-clock check: bus enable must stay low while enable has been low for 3 samples (R5)
   logic [2:0] en_hist = '0;
   always @(negedge clk) begin
      if (rst_n && en_hist == 3'b000 && !host_en)
         chk(bus_oe == 1'b0, "R5 idle bus_oe", bus_oe, 0);
      en_hist <= {en_hist[1:0], host_en};
   end

   logic [7:0] rd_val;
   logic       oe_seen, cs, ds, er;

   task automatic xfer(input logic rs, input logic rw, input logic [7:0] d_early,
                       input logic [7:0] d_late);
      @(negedge clk);
      host_rs = rs; host_rw = rw; bus_in = d_early; host_en = 1'b1;
      repeat (2) @(negedge clk);
      bus_in = d_late;
      repeat (2) @(negedge clk);
      rd_val  = bus_out;
      oe_seen = bus_oe;
      host_en = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      cs = cmd_stb; ds = wdat_stb; er = wr_err;
      chk(bus_oe == 1'b0, "R5 oe released", bus_oe, 0);
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk(busy == 0 && bus_oe == 0 && cmd_stb == 0 && wr_err == 0, "R5 reset outputs",
          {busy, bus_oe, cmd_stb, wr_err}, 0);
      chk(wide_mode == 1, "R10 reset width", wide_mode, 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      xfer(0, 1, 8'h00, 8'h00);
      chk(oe_seen == 1, "R5 oe during read", oe_seen, 1);
      chk(rd_val == 8'h00, "R3 status after reset", rd_val, 0);

      // Instruction load address 0x05
      xfer(0, 0, 8'h85, 8'h85);
      chk(cs == 1 && cmd_q == 8'h85, "R1 instruction latch", cmd_q, 8'h85);
      exp_addr = 5;
      chk(busy == 1, "R6 busy after instruction", busy, 1);
      xfer(0, 1, 8'h00, 8'h00);
      chk(rd_val == 8'h80 + exp_addr, "R3 R8 status busy+addr", rd_val, 8'h80 + exp_addr);

      // Data write while busy is dropped
      xfer(1, 0, 8'h3C, 8'h3C);
      chk(er == 1 && ds == 0, "R7 drop while busy", {er, ds}, 2'b10);
      chk(wdat_q == 8'h00, "R7 data unchanged", wdat_q, 0);
      wait_idle();
      xfer(0, 1, 8'h00, 8'h00);
      chk(rd_val == exp_addr, "R7 address unchanged", rd_val, exp_addr);

      // Data write with bus changing during enable; count busy
      xfer(1, 0, 8'hFF, 8'h5A);
      exp_wdat = 8'h5A; exp_addr++;
      chk(ds == 1 && wdat_q == exp_wdat, "R4 R2 late data captured", wdat_q, exp_wdat);
      begin
         int n = 0;
         while (busy) begin n++; @(negedge clk); end
         chk(n == BUSY_N, "R6 busy length", n, BUSY_N);
      end
      xfer(0, 1, 8'h00, 8'h00);
      chk(rd_val == exp_addr, "R9 step after data write", rd_val, exp_addr);

      xfer(1, 1, 8'h00, 8'h00);
      chk(rd_val == exp_wdat, "R2 data read", rd_val, exp_wdat);
      exp_addr++;
      xfer(0, 1, 8'h00, 8'h00);
      chk(rd_val == exp_addr, "R9 step after data read", rd_val, exp_addr);

      // Load 127, keep 8-bit, then wrap
      xfer(0, 0, 8'hFF, 8'hFF);
      chk(wide_mode == 1, "R10 width stays 8", wide_mode, 1);
      wait_idle();
      xfer(0, 1, 8'h00, 8'h00);
      chk(rd_val == 8'h7F, "R8 load 127", rd_val, 8'h7F);
      xfer(1, 1, 8'h00, 8'h00);
      exp_addr = 0;
      xfer(0, 1, 8'h00, 8'h00);
      chk(rd_val == 8'h00, "R9 wrap to 0", rd_val, 0);

      // Switch to 4-bit
      xfer(0, 0, 8'h20, 8'h20);
      chk(wide_mode == 0, "R10 width to 4", wide_mode, 0);
      wait_idle();

      xfer(1, 0, 8'hAF, 8'hAF);
      chk(ds == 0 && cs == 0 && er == 0, "R11 first nibble no strobe", {ds, cs, er}, 0);
      xfer(1, 0, 8'h7C, 8'h7C);
      exp_wdat = 8'hA7; exp_addr = 1;
      chk(ds == 1 && wdat_q == exp_wdat, "R11 nibble assembly", wdat_q, exp_wdat);
      wait_idle();

      xfer(1, 1, 8'h00, 8'h00);
      chk(rd_val == 8'hA0, "R11 read high nibble", rd_val, 8'hA0);
      xfer(1, 1, 8'h00, 8'h00);
      chk(rd_val == 8'h70, "R11 read low nibble", rd_val, 8'h70);
      exp_addr = 2;
      xfer(0, 1, 8'h00, 8'h00);
      chk(rd_val == 8'h00, "R11 status high nibble", rd_val, 0);
      xfer(0, 1, 8'h00, 8'h00);
      chk(rd_val == 8'h20, "R11 R3 status low nibble", rd_val, 8'h20);

      // Back to 8-bit through two nibbles
      xfer(0, 0, 8'h35, 8'h35);
      xfer(0, 0, 8'h0A, 8'h0A);
      chk(cs == 1 && cmd_q == 8'h30, "R1 R11 nibble instruction", cmd_q, 8'h30);
      chk(wide_mode == 1, "R10 width back to 8", wide_mode, 1);
      xfer(0, 1, 8'h00, 8'h00);
      chk(rd_val == 8'h82, "R3 busy flag after width change", rd_val, 8'h82);

      done = 1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
      if (!done) chk(1'b0, "watchdog", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule